// File: doc/BRIEF.md
# Melody and buzzer tone generator

This block drives a single square-wave pin for a sound transducer. It runs on a 32.768 kHz clock and has two personalities. In melody mode it plays a stream of note codes. Each code carries a scale step and a tone length, and a global tempo setting scales every length. A one-entry note buffer with a valid/ready handshake lets software queue the next code while the current one sounds. When a note ends, a one-cycle interrupt fires and the buffered code starts on the very next cycle. In buzzer mode the block makes a tone whose frequency and duty level come from configuration, using one of four patterns.

Configuration is written through a small register-style port. The output polarity can be inverted, so the idle level can be either high or low.

The controller is a state machine with these states:
- `ST_IDLE`: run bit clear, output inactive.
- `ST_MWAIT`: melody armed, no note playing.
- `ST_MPLAY`: a note or rest is sounding.
- `ST_BON`: buzzer tone window.
- `ST_BOFF`: buzzer silent window of the intermittent pattern.
- `ST_BDONE`: single burst finished.
- `ST_BFOLLOW`: output follows the run bit.

The transitions are as follows:
- Clearing run sends any state to `ST_IDLE`.
- From `ST_IDLE`, run goes to `ST_MWAIT` (melody), `ST_BFOLLOW` (buzzer pattern 3) or `ST_BON` (other buzzer patterns).
- `ST_MWAIT` goes to `ST_MPLAY` when the buffer holds a code.
- At the end of a note, `ST_MPLAY` either reloads itself from the buffer or falls back to `ST_MWAIT`.
- When the burst counter expires, `ST_BON` goes to `ST_BDONE` (single pattern) or to `ST_BOFF` (intermittent pattern).
- When the burst counter expires, `ST_BOFF` returns to `ST_BON`.

Top module: `mel_tone_gen`

## Requirements
- R1: After reset, tone_out is 0, irq is 0 and note_ready is 1.
- R2: A note code holds the scale step in bits [10:6] and the length in bits [5:0]. For a scale step s from 1 to 29, the output starts at its active level and toggles every 30−s clock cycles.
- R3: A note lasts L × T × TICK_UNIT cycles, where L is the length and T is the effective tempo. The count runs from the first cycle the note sounds to the cycle in which irq is high. A length of 0 is played as 1.
- R4: Tempo code 0 is played as tempo 15. Codes 1 to 15 are used as they are.
- R5: Scale step 0, 30 or 31 is a rest. The output stays at its inactive level for the whole note duration.
- R6: note_ready is high while the one-entry buffer is empty. A code is accepted on a clock edge where both note_valid and note_ready are high. A buffered code starts in the cycle right after the previous note ends, so consecutive irq pulses are spaced by exactly the later note's duration.
- R7: The configuration registers are as follows. Address 0 holds bit0 run, bit1 buzzer select and bit2 invert. Address 1 holds tempo in [3:0]. Address 2 holds duty in [7:4] and frequency in [2:0]. Address 3 holds the buzzer pattern in [1:0]. When run is cleared, the block returns to idle with the output inactive.
- R8: In buzzer pattern 0 (continuous), let k = frequency+1. The period is 16·k cycles, and the output is active for the first (duty+1)·k cycles of each period. The period count starts on the first tone cycle.
- R9: In buzzer pattern 1 (single), the tone sounds for BURST_CYC cycles, then the output stays inactive until run is cleared. One irq pulse marks the end of the burst.
- R10: In buzzer pattern 2 (intermittent), BURST_CYC cycles of tone alternate with BURST_CYC inactive cycles. The period count restarts at the start of each tone window.
- R11: In buzzer pattern 3 (follow), the output is held at its active level while run is set.
- R12: tone_out equals the active level XOR invert, so the inactive level equals the invert bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz tone clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| note_valid | input | 1 | Note code offered |
| note_code | input | 11 | Scale step [10:6], length [5:0] |
| note_ready | output | 1 | Note buffer empty, code will be taken |
| irq | output | 1 | One-cycle pulse at note end or at single-burst end |
| tone_out | output | 1 | Square-wave output pin |

## Verification
The bench builds the block with TICK_UNIT = 4 and BURST_CYC = 256. With these values the longest note (length 63 at tempo 15) lasts 3780 cycles. That makes every length, every tempo code including the invalid 0, and every scale step practical to sweep, with randomized and directed notes mixed. The 256-cycle burst window spans several whole or partial buzzer periods at every frequency code. The bench therefore checks single and intermittent bursts against a per-cycle count of the expected duty pattern, and it confirms that the period count restarts at each tone window.

// File: rtl/mel_pkg.sv
package mel_pkg;
    localparam int SCALE_W   = 5;
    localparam int LEN_W     = 6;
    localparam int NOTE_W    = SCALE_W + LEN_W;
    localparam int SCALE_TOP = 29;

    typedef enum logic [2:0] {
        ST_IDLE, ST_MWAIT, ST_MPLAY, ST_BON, ST_BOFF, ST_BDONE, ST_BFOLLOW
    } mel_state_e;

    typedef enum logic [1:0] {
        BZ_CONT = 2'd0, BZ_SINGLE = 2'd1, BZ_INTER = 2'd2, BZ_FOLLOW = 2'd3
    } buz_mode_e;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic [LEN_W-1:0]   len;
    } note_t;

    // Half period in clock cycles for a scale step; higher step, higher pitch.
    function automatic logic [SCALE_W-1:0] half_period(input logic [SCALE_W-1:0] s);
        return SCALE_W'(SCALE_TOP + 1) - s;
    endfunction
endpackage

// File: rtl/mel_cfg_regs.sv
module mel_cfg_regs (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          addr,
    input  logic [7:0]          wdata,
    output logic                run,
    output logic                buz_sel,
    output logic                invert,
    output logic [3:0]          tempo,
    output logic [2:0]          bfreq,
    output logic [3:0]          bduty,
    output mel_pkg::buz_mode_e  bmode
);
    import mel_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= 1'b0;
            buz_sel <= 1'b0;
            invert  <= 1'b0;
            tempo   <= '0;
            bfreq   <= '0;
            bduty   <= '0;
            bmode   <= BZ_CONT;
        end else if (we) begin
            unique case (addr)
                2'd0: begin
                    run     <= wdata[0];
                    buz_sel <= wdata[1];
                    invert  <= wdata[2];
                end
                2'd1: tempo <= wdata[3:0];
                2'd2: begin
                    bduty <= wdata[7:4];
                    bfreq <= wdata[2:0];
                end
                2'd3: bmode <= buz_mode_e'(wdata[1:0]);
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mel_note_buf.sv
module mel_note_buf (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [mel_pkg::NOTE_W-1:0]      in_code,
    input  logic                            take,
    output logic                            out_ready,
    output logic                            full,
    output mel_pkg::note_t                  code
);
    import mel_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            code <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            code <= note_t'(in_code);
        end
    end

    assign out_ready = !full;

    // R6: the buffer only fills after an offered code
    p_fill_on_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(in_valid));
endmodule

// File: rtl/mel_tone_gen.sv
module mel_tone_gen #(
    parameter int TICK_UNIT = 512,
    parameter int BURST_CYC = 4096
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [1:0]                  cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    input  logic                        note_valid,
    input  logic [mel_pkg::NOTE_W-1:0]  note_code,
    output logic                        note_ready,
    output logic                        irq,
    output logic                        tone_out
);
    import mel_pkg::*;

    localparam int TICK_MAX = 15 * TICK_UNIT;
    localparam int TK_W     = $clog2(TICK_MAX + 1);
    localparam int BU_W     = $clog2(BURST_CYC + 1);

    logic             run, buz_sel, invert;
    logic [3:0]       tempo, tempo_eff, bduty;
    logic [2:0]       bfreq;
    buz_mode_e        bmode;
    logic             buf_full, take;
    note_t            buf_note, cur;
    mel_state_e       state, nxt;
    logic [TK_W-1:0]  tick_cnt, tick_lim;
    logic [LEN_W-1:0] len_cnt, len_eff;
    logic [SCALE_W-1:0] half_cnt, half;
    logic             wave, is_tone, tick_last, note_end, burst_last, raw;
    logic [6:0]       bz_cnt, bz_top;
    logic [4:0]       duty_p1;
    logic [3:0]       k_mul;
    logic [7:0]       hi_lim;
    logic [BU_W-1:0]  burst_cnt;

    mel_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .run(run), .buz_sel(buz_sel), .invert(invert), .tempo(tempo),
        .bfreq(bfreq), .bduty(bduty), .bmode(bmode)
    );

    mel_note_buf u_buf (
        .clk(clk), .rst_n(rst_n), .in_valid(note_valid), .in_code(note_code),
        .take(take), .out_ready(note_ready), .full(buf_full), .code(buf_note)
    );

    // Derived timing values
    always_comb begin
        tempo_eff  = (tempo == 4'd0) ? 4'd15 : tempo;
        tick_lim   = TK_W'(tempo_eff) * TK_W'(TICK_UNIT);
        tick_last  = (tick_cnt == tick_lim - 1'b1);
        len_eff    = (cur.len == '0) ? LEN_W'(1) : cur.len;
        is_tone    = (cur.scale != '0) && (cur.scale <= SCALE_W'(SCALE_TOP));
        half       = half_period(cur.scale);
        note_end   = (state == ST_MPLAY) && tick_last && (len_cnt == len_eff - 1'b1);
        bz_top     = {bfreq, 4'hF};
        duty_p1    = {1'b0, bduty} + 5'd1;
        k_mul      = {1'b0, bfreq} + 4'd1;
        hi_lim     = {3'b000, duty_p1} * {4'b0000, k_mul};
        burst_last = (burst_cnt == BU_W'(BURST_CYC - 1));
    end

    // Next-state logic
    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (!run) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (!buz_sel)                nxt = ST_MWAIT;
                    else if (bmode == BZ_FOLLOW) nxt = ST_BFOLLOW;
                    else                         nxt = ST_BON;
                end
                ST_MWAIT: if (buf_full) begin
                    nxt  = ST_MPLAY;
                    take = 1'b1;
                end
                ST_MPLAY: if (note_end) begin
                    if (buf_full) take = 1'b1;
                    else          nxt  = ST_MWAIT;
                end
                ST_BON: begin
                    if (burst_last && bmode == BZ_SINGLE)     nxt = ST_BDONE;
                    else if (burst_last && bmode == BZ_INTER) nxt = ST_BOFF;
                end
                ST_BOFF: if (burst_last) nxt = ST_BON;
                ST_BDONE, ST_BFOLLOW: ;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Note and buzzer counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur       <= '0;
            tick_cnt  <= '0;
            len_cnt   <= '0;
            half_cnt  <= '0;
            wave      <= 1'b0;
            bz_cnt    <= '0;
            burst_cnt <= '0;
            irq       <= 1'b0;
        end else begin
            irq <= note_end || (state == ST_BON && nxt == ST_BDONE);
            if (take) begin
                cur      <= buf_note;
                tick_cnt <= '0;
                len_cnt  <= '0;
                half_cnt <= '0;
                wave     <= 1'b1;
            end else if (state == ST_MPLAY) begin
                tick_cnt <= tick_last ? '0 : tick_cnt + 1'b1;
                if (tick_last) len_cnt <= len_cnt + 1'b1;
                if (half_cnt == half - 1'b1) begin
                    half_cnt <= '0;
                    wave     <= ~wave;
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
            end
            if (state != nxt) begin
                bz_cnt    <= '0;
                burst_cnt <= '0;
            end else if (state == ST_BON || state == ST_BOFF) begin
                bz_cnt    <= (bz_cnt == bz_top) ? '0 : bz_cnt + 1'b1;
                burst_cnt <= burst_last ? '0 : burst_cnt + 1'b1;
            end
        end
    end

    // Output
    always_comb begin
        unique case (state)
            ST_MPLAY:   raw = is_tone && wave;
            ST_BON:     raw = ({1'b0, bz_cnt} < hi_lim);
            ST_BFOLLOW: raw = 1'b1;
            default:    raw = 1'b0;
        endcase
        tone_out = raw ^ invert;
    end

    // R6: the buffer is consumed only when it holds a code
    p_take_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> buf_full);
    // R5: rests keep the pin at its inactive level
    p_rest_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MPLAY && !is_tone) |-> (tone_out == invert));
    // R11: follow pattern drives the active level
    p_follow_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BFOLLOW) |-> (tone_out != invert));
    // R7: clearing run returns the machine to idle
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (state == ST_IDLE));
    // R9: a finished single burst stays finished while run holds
    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BDONE && run) |=> (state == ST_BDONE));
    // R3: the length count never passes the note length
    p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MPLAY) |-> (len_cnt < len_eff));
    // R6: irq only follows a sounding note or burst
    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(state) == ST_MPLAY || $past(state) == ST_BON));
endmodule

// File: tb/mel_tone_gen_test.sv
module mel_tone_gen_test;
    localparam int TU = 4;
    localparam int BC = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        note_valid = 1'b0;
    logic [10:0] note_code = '0;
    logic        note_ready, irq, tone_out;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int irq_n = 0;
    int irq_t [0:63];
    logic inv = 1'b0;

    mel_tone_gen #(.TICK_UNIT(TU), .BURST_CYC(BC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .note_valid(note_valid), .note_code(note_code),
        .note_ready(note_ready), .irq(irq), .tone_out(tone_out)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;
    always @(negedge clk) if (irq) begin
        if (irq_n < 64) irq_t[irq_n] = cyc;
        irq_n++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dur_exp(input int len, input int tempo);
        return ((len == 0) ? 1 : len) * ((tempo == 0) ? 15 : tempo) * TU;
    endfunction

    function automatic int exp_high(input int k, input int d, input int n);
        int s = 0;
        for (int i = 0; i < n; i++) if ((i % (16 * k)) < (d + 1) * k) s++;
        return s;
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [10:0] c);
        @(negedge clk);
        while (!note_ready) @(negedge clk);
        note_valid = 1'b1; note_code = c;
        @(negedge clk);
        note_valid = 1'b0;
    endtask

    task automatic play_one(input logic [10:0] c, output int dur,
                            output int first_tog, output int act);
        logic prev;
        push(c);
        @(negedge clk);
        dur = 0; first_tog = -1; act = 0; prev = tone_out;
        while (!irq && dur < 20000) begin
            if (tone_out != inv) act++;
            if (first_tog < 0 && tone_out != prev) first_tog = dur;
            prev = tone_out;
            @(negedge clk);
            dur++;
        end
    endtask

    task automatic note_test(input int s, input int len, input int tempo);
        int d, ft, a;
        wr(2'd1, 8'(tempo));
        play_one({5'(s), 6'(len)}, d, ft, a);
        chk($sformatf("R3/R4 duration s=%0d len=%0d tempo=%0d", s, len, tempo), d, dur_exp(len, tempo));
        if (s == 0 || s > 29) chk($sformatf("R5 rest s=%0d", s), a, 0);
        else if (d > 30 - s) chk($sformatf("R2 half period s=%0d", s), ft, 30 - s);
    endtask

    task automatic buz_count(input int f, input int d, input int mode, input int win, output int act);
        wr(2'd0, 8'h00);
        wr(2'd2, {4'(d), 1'b0, 3'(f)});
        wr(2'd3, 8'(mode));
        wr(2'd0, {5'b0, inv, 2'b11});
        @(negedge clk);
        act = 0;
        for (int i = 0; i < win; i++) begin
            if (tone_out != inv) act++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(10 * 190000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int a, base, f, d;
        int nl [0:3];
        int t;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tone_out", int'(tone_out), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 note_ready", int'(note_ready), 1);

        // Melody mode, directed corners
        wr(2'd0, 8'h01);
        note_test(1, 10, 3);
        note_test(29, 10, 3);
        note_test(15, 0, 5);    // R3 length 0 plays as 1
        note_test(7, 5, 0);     // R4 tempo 0 plays as 15
        note_test(0, 6, 2);     // R5 rest
        note_test(30, 6, 2);
        note_test(31, 4, 1);
        // Random notes
        for (int r = 0; r < 8; r++) begin
            note_test(int'($urandom_range(0, 31)), int'($urandom_range(0, 20)),
                      int'($urandom_range(0, 15)));
        end

        // R6 back-to-back notes with no gap
        t = int'($urandom_range(1, 15));
        wr(2'd1, 8'(t));
        for (int k = 0; k < 4; k++) nl[k] = int'($urandom_range(1, 12));
        base = irq_n;
        fork
            for (int k = 0; k < 4; k++) push({5'(k * 7 + 1), 6'(nl[k])});
            wait (irq_n >= base + 4);
        join
        for (int k = 0; k < 3; k++)
            chk($sformatf("R6 irq spacing note %0d", k + 1),
                irq_t[base + k + 1] - irq_t[base + k], dur_exp(nl[k + 1], t));

        // R12 polarity in melody rest and idle
        inv = 1'b1;
        wr(2'd0, 8'h05);
        note_test(0, 3, 1);
        wr(2'd0, 8'h04);
        @(negedge clk); @(negedge clk);
        chk("R12/R7 idle level inverted", int'(tone_out), 1);
        inv = 1'b0;
        wr(2'd0, 8'h00);

        // R8 continuous buzzer
        for (int r = 0; r < 4; r++) begin
            f = (r == 0) ? 7 : int'($urandom_range(0, 7));
            d = (r == 1) ? 15 : int'($urandom_range(0, 15));
            buz_count(f, d, 0, 32 * (f + 1), a);
            chk($sformatf("R8 continuous f=%0d d=%0d", f, d), a, exp_high(f + 1, d, 32 * (f + 1)));
        end

        // R9 single burst and its irq
        f = 2; d = 5;
        base = irq_n;
        buz_count(f, d, 1, 3 * BC, a);
        chk("R9 single burst active count", a, exp_high(f + 1, d, BC));
        chk("R9 single burst irq count", irq_n - base, 1);

        // R10 intermittent bursts
        f = 4; d = 9;
        buz_count(f, d, 2, 4 * BC, a);
        chk("R10 intermittent active count", a, 2 * exp_high(f + 1, d, BC));

        // R11 follow, plus R12 inverted follow
        buz_count(0, 0, 3, 20, a);
        chk("R11 follow active", a, 20);
        inv = 1'b1;
        buz_count(0, 0, 3, 20, a);
        chk("R11/R12 follow inverted level", int'(tone_out), 0);
        inv = 1'b0;

        // R7 clearing run silences the buzzer
        buz_count(3, 15, 0, 10, a);
        wr(2'd0, 8'h02);
        @(negedge clk);
        a = 0;
        for (int i = 0; i < 40; i++) begin
            if (tone_out) a++;
            @(negedge clk);
        end
        chk("R7 run cleared output inactive", a, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule